// File: doc/BRIEF.md
# Admin Queue Enable Validator

This block decides whether a storage queue controller may start when the host sets the enable bit of its configuration word. It looks at the configuration word, the admin queue attribute word, the two admin queue base addresses, the page-size limits from the capability register and the entry-size limit bytes from the identify data. It also looks at two flags that say whether the admin submission and completion queues already exist. From these it gives a single pass or fail verdict.

The check runs once, on the clock edge that first sees enable high. On a pass the block raises `ready`. On a fail `ready` stays low and `fatal` is raised. In both cases the block also latches the page size, as a base-two logarithm of the byte count. The verdict holds until the host clears enable. The registers that hold these values, the reset sequence and all later queue processing live in other blocks.

Top module: `qctl_enable_validator`

## Requirements
- R1: After reset, `ready`, `fatal` and `page_shift` are all 0.
- R2: The page-size field is `cfg_word[10:7]` and the enable bit is `cfg_word[0]`. On the clock edge that first sees enable at 1, `page_shift` becomes the page-size field plus 12, so the page is 2^page_shift bytes.
- R3: Enable is refused when `admin_sq_live` or `admin_cq_live` is 1.
- R4: Enable is refused when `asq_base` or `acq_base` is zero.
- R5: Enable is refused when either base has a bit set below bit `page_shift`, which means it is not page aligned.
- R6: The page-size field must satisfy `cap_mps_min` <= field <= `cap_mps_max`, otherwise enable is refused.
- R7: The completion entry size field is `cfg_word[23:20]`. It must lie between `cqes_limits[3:0]` (minimum) and `cqes_limits[7:4]` (maximum), both inclusive.
- R8: The submission entry size field is `cfg_word[19:16]`. It must lie between `sqes_limits[3:0]` and `sqes_limits[7:4]`, both inclusive.
- R9: The admin queue sizes are `aqa_word[11:0]` (submission) and `aqa_word[27:16]` (completion). Each must be nonzero and no larger than 4095.
- R10: The verdict and `page_shift` are evaluated only on the rising edge of enable. Input changes while enable stays high have no effect.
- R11: On the first clock edge that sees enable at 0, `ready`, `fatal` and `page_shift` return to 0.
- R12: A pass gives `ready`=1 and `fatal`=0. A fail gives `ready`=0 and `fatal`=1. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word: enable, page size and entry sizes |
| aqa_word | input | 32 | Admin queue attribute word holding the two queue sizes |
| asq_base | input | 64 | Admin submission queue base address |
| acq_base | input | 64 | Admin completion queue base address |
| cap_mps_min | input | 4 | Smallest page-size field the controller allows |
| cap_mps_max | input | 4 | Largest page-size field the controller allows |
| sqes_limits | input | 8 | Submission entry size limits, max in [7:4], min in [3:0] |
| cqes_limits | input | 8 | Completion entry size limits, max in [7:4], min in [3:0] |
| admin_sq_live | input | 1 | Admin submission queue already exists |
| admin_cq_live | input | 1 | Admin completion queue already exists |
| ready | output | 1 | Controller may start |
| fatal | output | 1 | Enable refused |
| page_shift | output | 5 | Base-two logarithm of the page size in bytes |

## Verification
There is one register stage between the inputs and the results. `ready`, `fatal` and `page_shift` are due on the first rising edge after enable goes high, and they return to zero on the first rising edge after enable goes low. The bench changes inputs on the falling edge. It reads the verdict on the next falling edge, half a period after the edge that updates it. It then changes the fields while enable is still high, and one edge later it checks that nothing moved. After clearing enable it reads the outputs again one edge later. No check ever falls on the same edge where an input changes.

// File: rtl/qctl_en_pkg.sv
package qctl_en_pkg;
  localparam int CFG_W      = 32;
  localparam int EN_BIT     = 0;
  localparam int MPS_LO     = 7;
  localparam int NIB_W      = 4;
  localparam int SQES_LO    = 16;
  localparam int CQES_LO    = 20;
  localparam int AQ_W       = 12;
  localparam int AQ_SQ_LO   = 0;
  localparam int AQ_CQ_LO   = 16;
  localparam int PAGE_BASE  = 12;
  localparam int SHIFT_W    = 5;

  // page size exponent from the page-size field
  function automatic logic [SHIFT_W-1:0] shift_of(input logic [NIB_W-1:0] mps);
    return SHIFT_W'(mps) + SHIFT_W'(PAGE_BASE);
  endfunction

  // inclusive window test on a nibble
  function automatic logic nib_inside(input logic [NIB_W-1:0] v,
                                      input logic [NIB_W-1:0] lo,
                                      input logic [NIB_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/qctl_nib_window.sv
module qctl_nib_window
  import qctl_en_pkg::*;
(
  input  logic [NIB_W-1:0] value,
  input  logic [NIB_W-1:0] lo,
  input  logic [NIB_W-1:0] hi,
  output logic             ok
);
  assign ok = nib_inside(value, lo, hi);
endmodule

// File: rtl/qctl_base_check.sv
module qctl_base_check
  import qctl_en_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [SHIFT_W-1:0] shift,
  output logic               ok
);
  logic [ADDR_W-1:0] low_mask;
  logic nonzero, aligned;

  assign low_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
  assign nonzero  = |base;
  assign aligned  = ~|(base & low_mask);
  assign ok       = nonzero && aligned;
endmodule

// File: rtl/qctl_aq_size_check.sv
module qctl_aq_size_check
  import qctl_en_pkg::*;
#(
  parameter int MAX_ENTRIES = 4095
) (
  input  logic [AQ_W-1:0] size,
  output logic            ok
);
  assign ok = (size != '0) && (32'(size) <= MAX_ENTRIES);
endmodule

// File: rtl/qctl_enable_validator.sv
module qctl_enable_validator
  import qctl_en_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int AQ_MAX      = 4095
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic [CFG_W-1:0]     aqa_word,
  input  logic [ADDR_W-1:0]    asq_base,
  input  logic [ADDR_W-1:0]    acq_base,
  input  logic [NIB_W-1:0]     cap_mps_min,
  input  logic [NIB_W-1:0]     cap_mps_max,
  input  logic [2*NIB_W-1:0]   sqes_limits,
  input  logic [2*NIB_W-1:0]   cqes_limits,
  input  logic                 admin_sq_live,
  input  logic                 admin_cq_live,
  output logic                 ready,
  output logic                 fatal,
  output logic [SHIFT_W-1:0]   page_shift
);
  localparam int N_WIN  = 3;
  localparam int N_BASE = 2;
  localparam int N_AQ   = 2;

  logic en, en_q, en_rise;
  logic [NIB_W-1:0]   mps;
  logic [SHIFT_W-1:0] shift_now;

  assign en        = cfg_word[EN_BIT];
  assign en_rise   = en && !en_q;
  assign mps       = cfg_word[MPS_LO +: NIB_W];
  assign shift_now = shift_of(mps);

  // window checks: 0 page size, 1 submission entry, 2 completion entry
  logic [NIB_W-1:0] win_val [N_WIN];
  logic [NIB_W-1:0] win_lo  [N_WIN];
  logic [NIB_W-1:0] win_hi  [N_WIN];
  logic [N_WIN-1:0] win_ok;

  assign win_val[0] = mps;
  assign win_lo[0]  = cap_mps_min;
  assign win_hi[0]  = cap_mps_max;
  assign win_val[1] = cfg_word[SQES_LO +: NIB_W];
  assign win_lo[1]  = sqes_limits[NIB_W-1:0];
  assign win_hi[1]  = sqes_limits[2*NIB_W-1:NIB_W];
  assign win_val[2] = cfg_word[CQES_LO +: NIB_W];
  assign win_lo[2]  = cqes_limits[NIB_W-1:0];
  assign win_hi[2]  = cqes_limits[2*NIB_W-1:NIB_W];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    qctl_nib_window u_win (
      .value (win_val[g]),
      .lo    (win_lo[g]),
      .hi    (win_hi[g]),
      .ok    (win_ok[g])
    );
  end

  logic [ADDR_W-1:0] bases [N_BASE];
  logic [N_BASE-1:0] base_ok;
  assign bases[0] = asq_base;
  assign bases[1] = acq_base;

  for (genvar g = 0; g < N_BASE; g++) begin : g_base
    qctl_base_check #(.ADDR_W(ADDR_W)) u_base (
      .base  (bases[g]),
      .shift (shift_now),
      .ok    (base_ok[g])
    );
  end

  logic [AQ_W-1:0] aq_size [N_AQ];
  logic [N_AQ-1:0] aq_ok;
  assign aq_size[0] = aqa_word[AQ_SQ_LO +: AQ_W];
  assign aq_size[1] = aqa_word[AQ_CQ_LO +: AQ_W];

  for (genvar g = 0; g < N_AQ; g++) begin : g_aq
    qctl_aq_size_check #(.MAX_ENTRIES(AQ_MAX)) u_aq (
      .size (aq_size[g]),
      .ok   (aq_ok[g])
    );
  end

  // the checks in their fixed order, all must hold
  logic queues_free, verdict_ok;
  assign queues_free = !admin_sq_live && !admin_cq_live;
  assign verdict_ok  = queues_free && (&base_ok) && win_ok[0]
                       && win_ok[2] && win_ok[1] && (&aq_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      ready      <= 1'b0;
      fatal      <= 1'b0;
      page_shift <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        ready      <= 1'b0;
        fatal      <= 1'b0;
        page_shift <= '0;
      end else if (en_rise) begin
        ready      <= verdict_ok;
        fatal      <= !verdict_ok;
        page_shift <= shift_now;
      end
    end
  end
endmodule

// File: rtl/qctl_enable_validator_chk.sv
module qctl_enable_validator_chk
  import qctl_en_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CFG_W-1:0]   cfg_word,
  input logic [63:0]        asq_base,
  input logic [63:0]        acq_base,
  input logic               admin_sq_live,
  input logic               admin_cq_live,
  input logic               en_rise,
  input logic               verdict_ok,
  input logic               ready,
  input logic               fatal,
  input logic [SHIFT_W-1:0] page_shift
);
  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && fatal));

  assert_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (ready == $past(verdict_ok)) && (fatal != $past(verdict_ok)));

  assert_live_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && (admin_sq_live || admin_cq_live)) |=> fatal && !ready);

  assert_zero_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && (asq_base == 64'd0 || acq_base == 64'd0)) |=> fatal);

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> page_shift == 5'($past(cfg_word[10:7])) + 5'd12);

  assert_only_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) || $rose(fatal)) |-> $past(en_rise));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[0] |=> !ready && !fatal && page_shift == '0);
endmodule

bind qctl_enable_validator qctl_enable_validator_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_word      (cfg_word),
  .asq_base      (asq_base),
  .acq_base      (acq_base),
  .admin_sq_live (admin_sq_live),
  .admin_cq_live (admin_cq_live),
  .en_rise       (en_rise),
  .verdict_ok    (verdict_ok),
  .ready         (ready),
  .fatal         (fatal),
  .page_shift    (page_shift)
);

// File: tb/test_qctl_enable_validator.sv
module test_qctl_enable_validator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] d_cfg = '0, d_aqa = '0;
  logic [63:0] d_asq = '0, d_acq = '0;
  logic [3:0]  d_min = '0, d_max = '0;
  logic [7:0]  d_sql = '0, d_cql = '0;
  logic        d_ls = 1'b0, d_lc = 1'b0;
  logic        ready, fatal;
  logic [4:0]  page_shift;

  int checks = 0;
  int errors = 0;

  // trial settings
  logic [3:0]  t_mps, t_sq, t_cq, t_min, t_max;
  logic [7:0]  t_sql, t_cql;
  logic [11:0] t_asz, t_csz;
  logic [63:0] t_asq, t_acq;
  logic        t_ls, t_lc;

  always #10 clk = ~clk;

  qctl_enable_validator i_qctl_enable_validator (
    .clk(clk), .rst_n(rst_n), .cfg_word(d_cfg), .aqa_word(d_aqa),
    .asq_base(d_asq), .acq_base(d_acq), .cap_mps_min(d_min), .cap_mps_max(d_max),
    .sqes_limits(d_sql), .cqes_limits(d_cql), .admin_sq_live(d_ls),
    .admin_cq_live(d_lc), .ready(ready), .fatal(fatal), .page_shift(page_shift)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    t_mps = 4'd0; t_sq = 4'd6; t_cq = 4'd4; t_min = 4'd0; t_max = 4'd15;
    t_sql = 8'hF6; t_cql = 8'hF4; t_asz = 12'd31; t_csz = 12'd31;
    t_asq = 64'h1000_0000; t_acq = 64'h2000_0000; t_ls = 1'b0; t_lc = 1'b0;
  endtask

  function automatic bit in_win(input int v, input int lo, input int hi);
    return v >= lo && v <= hi;
  endfunction

  function automatic bit model_ok();
    longint unsigned pg = 64'd1 << (int'(t_mps) + 12);
    bit r = 1;
    if (t_ls || t_lc) r = 0;
    if (t_asq == 0 || t_acq == 0) r = 0;
    if ((t_asq % pg) != 0 || (t_acq % pg) != 0) r = 0;
    if (!in_win(t_mps, t_min, t_max)) r = 0;
    if (!in_win(t_cq, t_cql[3:0], t_cql[7:4])) r = 0;
    if (!in_win(t_sq, t_sql[3:0], t_sql[7:4])) r = 0;
    if (t_asz == 0 || t_csz == 0) r = 0;
    return r;
  endfunction

  task automatic trial(input string tag);
    bit exp_ok = model_ok();
    int exp_sh = int'(t_mps) + 12;
    @(negedge clk);
    d_cfg = 32'd0;
    @(negedge clk);
    d_cfg = 32'd1 | (32'(t_mps) << 7) | (32'(t_sq) << 16) | (32'(t_cq) << 20);
    d_aqa = 32'(t_asz) | (32'(t_csz) << 16);
    d_asq = t_asq; d_acq = t_acq; d_min = t_min; d_max = t_max;
    d_sql = t_sql; d_cql = t_cql; d_ls = t_ls; d_lc = t_lc;
    @(negedge clk);
    chk(tag, {31'd0, ready}, {31'd0, exp_ok});
    chk("R12", {31'd0, fatal}, {31'd0, !exp_ok});
    chk("R2", 32'(page_shift), 32'(exp_sh));
    // R10: disturb every input while enable stays high
    d_cfg = d_cfg ^ 32'h00FF_0780;
    d_asq = exp_ok ? 64'd0 : 64'h4000_0000;
    d_acq = exp_ok ? 64'd3 : 64'h4000_0000;
    d_ls = exp_ok; d_lc = exp_ok; d_aqa = exp_ok ? 32'd0 : 32'h0001_0001;
    d_min = 4'd0; d_max = 4'd15; d_sql = 8'hF0; d_cql = 8'hF0;
    @(negedge clk);
    chk("R10", {30'd0, ready, fatal}, {30'd0, exp_ok, !exp_ok});
    chk("R10", 32'(page_shift), 32'(exp_sh));
    d_cfg = d_cfg & ~32'd1;
    @(negedge clk);
    chk("R11", {27'd0, ready, fatal, 3'd0}, 32'd0);
    chk("R11", 32'(page_shift), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {29'd0, ready, fatal, 1'b0}, 32'd0);
    chk("R1", 32'(page_shift), 32'd0);
    rst_n = 1'b1;

    defaults(); trial("R12");

    // R6: page-size sweep against a narrow capability window
    for (int m = 0; m < 16; m++) begin
      defaults(); t_min = 4'd2; t_max = 4'd9; t_mps = 4'(m);
      t_asq = 64'h0800_0000; t_acq = 64'h1000_0000;
      trial("R6");
    end

    // R5: alignment sweep of each base at page shift 16
    for (int b = 0; b < 22; b++) begin
      defaults(); t_mps = 4'd4; t_asq = 64'd1 << b; trial("R5");
      defaults(); t_mps = 4'd4; t_acq = 64'd1 << b; trial("R5");
    end
    defaults(); t_mps = 4'd15; t_asq = 64'h0800_0000; t_acq = 64'h0C00_0000;
    trial("R5");

    // R4: zero bases
    defaults(); t_asq = 64'd0; trial("R4");
    defaults(); t_acq = 64'd0; trial("R4");

    // R3: queues already present
    for (int k = 1; k < 4; k++) begin
      defaults(); t_ls = k[0]; t_lc = k[1]; trial("R3");
    end

    // R7 and R8: entry size sweeps
    for (int e = 0; e < 16; e++) begin
      defaults(); t_cql = 8'h94; t_cq = 4'(e); trial("R7");
      defaults(); t_sql = 8'hA6; t_sq = 4'(e); trial("R8");
    end

    // R9: admin queue sizes
    defaults(); t_asz = 12'd0; trial("R9");
    defaults(); t_csz = 12'd0; trial("R9");
    defaults(); t_asz = 12'd4095; t_csz = 12'd4095; trial("R9");
    defaults(); t_asz = 12'd1; t_csz = 12'd1; trial("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule